// File: doc/BRIEF.md
# Head-Per-Track Disk Controller Register File

This block is the register set that software sees for a head-per-track disk controller that drives one to four platters. It decodes eight 16-bit registers from bits 3:1 of the bus address and accepts both word and byte writes. It holds the control/status handshake: done, interrupt enable, abort and the GO start. It rejects a disk address that names a missing platter at the moment that address is written. It also keeps a look-ahead register that moves forward by one word each time it is read, which stands in for the rotating disk under the heads.

A separate transfer sequencer does the data movement. This block gives it a start pulse with the function latched at GO, an abort pulse, the disk address, the word count, the 18-bit memory address and the mode bits. The sequencer reports back through strobes: a done pulse, set strobes for the control/status error bits and for the error-status register, and a load for the data buffer.

Top module: `hptd_regfile`

## Requirements
- R1: The bus register index is address bits 3:1: 0 look-ahead, 1 disk address, 2 error status, 3 control/status, 4 word count, 5 current address, 6 maintenance, 7 data buffer. Writes to indices 0, 2 and 7 change nothing.
- R2: When byte select is 1, the byte to write is taken from wdata[7:0]. Address bit 0 = 1 puts it in the upper byte and 0 puts it in the lower byte, and the other byte is kept. When byte select is 0, the whole word is written.
- R3: A disk-address write stores 13 bits. If bits 12:11 are at or above the configured platter count, the nonexistent-disk flag (control/status bit 11) is set and the look-ahead register is left as it was. Otherwise the flag is cleared and the look-ahead register takes the new disk address.
- R4: A look-ahead read returns the register's 13 bits. Bit 15 is 1 when the nonexistent-disk flag or error-status bit 5 (overflow) is set. After each read, the low 6 bits count up modulo 64 and bits 12:6 stay the same.
- R5: The control/status bits read as: 15 error summary, 14:10 error flags, 9 inhibit increment, 8 abort (reads 0), 7 done, 6 interrupt enable, 5:4 memory extension, 3 maintenance, 2:1 function, 0 GO (reads 0). The summary bit is 1 exactly when any of bits 14:10 is set or error status is nonzero.
- R6: Writing GO=1 while done is 1 latches the function onto seq_func, clears bits 15:10, done and error status, and drops irq. seq_start pulses for one cycle after the write. GO written while done is 0 starts nothing.
- R7: Writing abort=1 sets done and gives a one-cycle seq_abort pulse after the write.
- R8: irq goes to 1 when done rises while interrupt enable is 1. It also goes to 1 when interrupt enable is written to 1 while it was 0 and done is 1. Writing interrupt enable as 0 clears irq.
- R9: Software writes reach only control/status bits 9:0. A current-address write forces bit 0 to zero. A maintenance write keeps only bits 15:6.
- R10: After reset, control/status reads 0x0080 (done only), every other register reads 0, and irq is 0.
- R11: seq_done sets done. seq_err_set[4:0] sets control/status bits 14:10. seq_er_set is ORed into error status. seq_db_load loads the data buffer from seq_db_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte write select |
| bus_addr | input | 4 | Bits 3:1 register index, bit 0 byte lane |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| seq_start | output | 1 | Start pulse to the sequencer |
| seq_abort | output | 1 | Abort pulse to the sequencer |
| seq_func | output | 2 | Function latched at GO |
| seq_disk_addr | output | 13 | Disk address |
| seq_word_cnt | output | 16 | Word count |
| seq_mem_addr | output | 18 | Memory extension and current address |
| seq_inhibit | output | 1 | Inhibit address increment |
| seq_maint | output | 1 | Maintenance mode bit |
| seq_done | input | 1 | Sequencer finished |
| seq_err_set | input | 5 | Set strobes for control/status bits 14:10 |
| seq_er_set | input | 16 | Bits ORed into error status |
| seq_db_load | input | 1 | Load data buffer |
| seq_db_val | input | 16 | Data buffer value |

## Verification
The assertions check the following on every cycle. A start pulse always arrives with done, the error bits, error status and irq all cleared. An abort pulse without a start always leaves done set. irq never stays high without interrupt enable, and it always follows a rise of done while enable is set. Every look-ahead read moves only the low six bits on by one. A bad platter write always raises the nonexistent-disk flag. Some behaviour only the directed scenarios can show: byte-lane merging, the look-ahead wrap from 63 to 0, the read-only registers, GO being refused while busy, the interrupt raised by enabling after done, and the exact values read back from each register.

// File: rtl/hptd_pkg.sv
package hptd_pkg;
  localparam int REG_W   = 16;
  localparam int DA_W    = 13;
  localparam int SPIN_W  = 6;
  localparam int ERR_N   = 5;
  localparam int OVFL_BIT = 5;

  typedef enum logic [2:0] {
    RS_LOOK  = 3'd0,
    RS_DADDR = 3'd1,
    RS_ERSTA = 3'd2,
    RS_CTL   = 3'd3,
    RS_WCNT  = 3'd4,
    RS_CADDR = 3'd5,
    RS_MAINT = 3'd6,
    RS_DBUF  = 3'd7
  } reg_sel_e;

  // Byte-lane merge of a write into the old register value.
  function automatic logic [REG_W-1:0] merge_lane(input logic [REG_W-1:0] old_v,
                                                  input logic [REG_W-1:0] new_v,
                                                  input logic byte_en,
                                                  input logic odd);
    if (!byte_en)  return new_v;
    else if (odd)  return {new_v[7:0], old_v[7:0]};
    else           return {old_v[15:8], new_v[7:0]};
  endfunction

  // Rotation step of the look-ahead position.
  function automatic logic [DA_W-1:0] spin_step(input logic [DA_W-1:0] la);
    return {la[DA_W-1:SPIN_W], la[SPIN_W-1:0] + {{(SPIN_W-1){1'b0}}, 1'b1}};
  endfunction

  function automatic logic [1:0] platter_of(input logic [DA_W-1:0] da);
    return da[DA_W-1:DA_W-2];
  endfunction
endpackage

// File: rtl/hptd_decode.sv
module hptd_decode #(
  parameter int N_REG = 8,
  localparam int SEL_W = $clog2(N_REG)
) (
  input  logic             en,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  output logic [N_REG-1:0] wr_hit,
  output logic [N_REG-1:0] rd_hit
);
  for (genvar i = 0; i < N_REG; i++) begin : g_hit
    assign wr_hit[i] = en &  wr & (sel == SEL_W'(i));
    assign rd_hit[i] = en & ~wr & (sel == SEL_W'(i));
  end
endmodule

// File: rtl/hptd_lookahead.sv
module hptd_lookahead
  import hptd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DA_W-1:0] load_val,
  input  logic            advance,
  output logic [DA_W-1:0] la_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       la_q <= '0;
    else if (load)    la_q <= load_val;
    else if (advance) la_q <= spin_step(la_q);
  end
endmodule

// File: rtl/hptd_csr.sv
module hptd_csr
  import hptd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_wr,
  input  logic [REG_W-1:0] cs_val,
  input  logic             ned_set,
  input  logic             ned_clr,
  input  logic             seq_done,
  input  logic [ERR_N-1:0] seq_err_set,
  input  logic [REG_W-1:0] seq_er_set,
  output logic [REG_W-1:0] cs_word,
  output logic [REG_W-1:0] er_q,
  output logic [ERR_N-1:0] err_bits,
  output logic             irq,
  output logic             start_q,
  output logic             abort_q,
  output logic             done_q,
  output logic             ie_q,
  output logic [1:0]       run_func,
  output logic             inh_q,
  output logic [1:0]       mex_q,
  output logic             maint_q
);
  logic [1:0]       func_q;
  logic             abort_evt, start_evt, ie_next, done_set, done_rise, err_sum;
  logic [ERR_N-1:0] ned_mask;

  assign abort_evt = cs_wr & cs_val[8];
  assign start_evt = cs_wr & cs_val[0] & (done_q | cs_val[8]);
  assign ie_next   = cs_wr ? cs_val[6] : ie_q;
  assign done_set  = abort_evt | seq_done;
  assign done_rise = done_set & ~done_q & ~start_evt;
  assign ned_mask  = ERR_N'(2);
  assign err_sum   = (|err_bits) | (|er_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b1; ie_q <= 1'b0; inh_q <= 1'b0; mex_q <= '0; maint_q <= 1'b0;
      func_q <= '0; run_func <= '0; err_bits <= '0; er_q <= '0; irq <= 1'b0;
      start_q <= 1'b0; abort_q <= 1'b0;
    end else begin
      start_q <= start_evt;
      abort_q <= abort_evt;
      if (cs_wr) begin
        inh_q   <= cs_val[9];
        ie_q    <= cs_val[6];
        mex_q   <= cs_val[5:4];
        maint_q <= cs_val[3];
        func_q  <= cs_val[2:1];
      end
      if (start_evt) begin
        done_q   <= 1'b0;
        err_bits <= '0;
        er_q     <= '0;
        run_func <= cs_val[2:1];
      end else begin
        if (done_set) done_q <= 1'b1;
        err_bits <= (err_bits & ~(ned_clr ? ned_mask : '0)) | seq_err_set
                    | (ned_set ? ned_mask : '0);
        er_q <= er_q | seq_er_set;
      end
      if (start_evt)                                 irq <= 1'b0;
      else if (done_rise && ie_next)                 irq <= 1'b1;
      else if (cs_wr && !cs_val[6])                  irq <= 1'b0;
      else if (cs_wr && cs_val[6] && !ie_q && done_q) irq <= 1'b1;
    end
  end

  assign cs_word = {err_sum, err_bits, inh_q, 1'b0, done_q, ie_q, mex_q, maint_q, func_q, 1'b0};
endmodule

// File: rtl/hptd_regfile.sv
module hptd_regfile
  import hptd_pkg::*;
#(
  parameter int NUM_PLATTERS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic        bus_byte,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        seq_start,
  output logic        seq_abort,
  output logic [1:0]  seq_func,
  output logic [12:0] seq_disk_addr,
  output logic [15:0] seq_word_cnt,
  output logic [17:0] seq_mem_addr,
  output logic        seq_inhibit,
  output logic        seq_maint,
  input  logic        seq_done,
  input  logic [4:0]  seq_err_set,
  input  logic [15:0] seq_er_set,
  input  logic        seq_db_load,
  input  logic [15:0] seq_db_val
);
  localparam int N_REG = 8;

  logic [N_REG-1:0] wr_hit, rd_hit;
  logic [REG_W-1:0] view, merged, cs_word, er_q;
  logic [DA_W-1:0]  da_q, la_q;
  logic [REG_W-1:0] wc_q, ca_q, mn_q, db_q;
  logic [ERR_N-1:0] err_bits;
  logic [1:0]       mex_q;
  logic             done_q, ie_q, inh_q, maint_q, ned_q, la_bad;
  logic             da_wr_evt, da_bad, la_rd_evt;

  hptd_decode #(.N_REG(N_REG)) u_dec (
    .en(bus_en), .wr(bus_wr), .sel(bus_addr[3:1]), .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  assign ned_q  = err_bits[1];
  assign la_bad = ned_q | er_q[OVFL_BIT];

  always_comb begin
    case (reg_sel_e'(bus_addr[3:1]))
      RS_LOOK:  view = {la_bad, 2'b00, la_q};
      RS_DADDR: view = {3'b000, da_q};
      RS_ERSTA: view = er_q;
      RS_CTL:   view = cs_word;
      RS_WCNT:  view = wc_q;
      RS_CADDR: view = ca_q;
      RS_MAINT: view = mn_q;
      default:  view = db_q;
    endcase
  end
  assign bus_rdata = view;
  assign merged    = merge_lane(view, bus_wdata, bus_byte, bus_addr[0]);

  assign da_wr_evt = wr_hit[RS_DADDR];
  assign da_bad    = 32'(platter_of(merged[DA_W-1:0])) >= NUM_PLATTERS;
  assign la_rd_evt = rd_hit[RS_LOOK];

  hptd_lookahead u_la (
    .clk(clk), .rst_n(rst_n), .load(da_wr_evt & ~da_bad),
    .load_val(merged[DA_W-1:0]), .advance(la_rd_evt), .la_q(la_q)
  );

  hptd_csr u_csr (
    .clk(clk), .rst_n(rst_n), .cs_wr(wr_hit[RS_CTL]), .cs_val(merged),
    .ned_set(da_wr_evt & da_bad), .ned_clr(da_wr_evt & ~da_bad),
    .seq_done(seq_done), .seq_err_set(seq_err_set), .seq_er_set(seq_er_set),
    .cs_word(cs_word), .er_q(er_q), .err_bits(err_bits), .irq(irq),
    .start_q(seq_start), .abort_q(seq_abort), .done_q(done_q), .ie_q(ie_q),
    .run_func(seq_func), .inh_q(inh_q), .mex_q(mex_q), .maint_q(maint_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      da_q <= '0; wc_q <= '0; ca_q <= '0; mn_q <= '0; db_q <= '0;
    end else begin
      if (da_wr_evt)          da_q <= merged[DA_W-1:0];
      if (wr_hit[RS_WCNT])    wc_q <= merged;
      if (wr_hit[RS_CADDR])   ca_q <= {merged[15:1], 1'b0};
      if (wr_hit[RS_MAINT])   mn_q <= {merged[15:6], 6'b0};
      if (seq_db_load)        db_q <= seq_db_val;
    end
  end

  assign seq_disk_addr = da_q;
  assign seq_word_cnt  = wc_q;
  assign seq_mem_addr  = {mex_q, ca_q};
  assign seq_inhibit   = inh_q;
  assign seq_maint     = maint_q;
endmodule

// File: rtl/hptd_regfile_chk.sv
module hptd_regfile_chk
  import hptd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             seq_start,
  input logic             seq_abort,
  input logic             irq,
  input logic             done_q,
  input logic             ie_q,
  input logic [REG_W-1:0] er_q,
  input logic [ERR_N-1:0] err_bits,
  input logic             la_rd_evt,
  input logic [DA_W-1:0]  la_q,
  input logic             ned_q,
  input logic             da_wr_evt,
  input logic             da_bad
);
  a_r6_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (!done_q && er_q == '0 && err_bits == '0 && !irq));

  a_r7_abort_done: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_abort && !seq_start) |-> done_q);

  a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && ie_q) |-> irq);

  a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q);

  a_r4_la_spin: assert property (@(posedge clk) disable iff (!rst_n)
    la_rd_evt |=> (la_q[DA_W-1:SPIN_W] == $past(la_q[DA_W-1:SPIN_W]) &&
                   la_q[SPIN_W-1:0] == $past(la_q[SPIN_W-1:0]) + 6'd1));

  a_r3_bad_platter: assert property (@(posedge clk) disable iff (!rst_n)
    (da_wr_evt && da_bad) |=> ned_q);
endmodule

bind hptd_regfile hptd_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .seq_abort(seq_abort),
  .irq(irq), .done_q(done_q), .ie_q(ie_q), .er_q(er_q), .err_bits(err_bits),
  .la_rd_evt(la_rd_evt), .la_q(la_q), .ned_q(ned_q),
  .da_wr_evt(da_wr_evt), .da_bad(da_bad)
);

// File: tb/test_hptd_regfile.sv
module test_hptd_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int PLAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_wr = 0, bus_byte = 0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic irq, seq_start, seq_abort, seq_inhibit, seq_maint;
  logic [1:0] seq_func;
  logic [12:0] seq_disk_addr;
  logic [15:0] seq_word_cnt;
  logic [17:0] seq_mem_addr;
  logic seq_done = 0, seq_db_load = 0;
  logic [4:0] seq_err_set = '0;
  logic [15:0] seq_er_set = '0, seq_db_val = '0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hptd_regfile #(.NUM_PLATTERS(PLAT)) i_hptd_regfile (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [15:0] d, input bit b = 0, input bit odd = 0);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_byte = b; bus_addr = {3'(r), odd}; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0; bus_byte = 0;
    #1;
  endtask

  task automatic rd(input int r, output logic [15:0] v);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = {3'(r), 1'b0};
    #1 v = bus_rdata;
    @(negedge clk);
    bus_en = 0;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R10 irq", {15'b0, irq}, 16'h0);
    rd(3, v); chk("R10 cs", v, 16'h0080);
    for (int r = 1; r < 8; r++) if (r != 3) begin rd(r, v); chk("R10 reg", v, 16'h0); end
  endtask

  task automatic t_readonly();
    logic [15:0] v;
    wr(0, 16'hFFFF); wr(2, 16'hFFFF); wr(7, 16'hFFFF);
    rd(2, v); chk("R1 er ro", v, 16'h0);
    rd(7, v); chk("R1 db ro", v, 16'h0);
    rd(0, v); chk("R1 la ro", v, 16'h0);
  endtask

  task automatic t_daddr();
    logic [15:0] v;
    wr(1, 16'h0845);
    rd(1, v); chk("R3 da", v, 16'h0845);
    chk("R3 seq da", {3'b0, seq_disk_addr}, 16'h0845);
    rd(0, v); chk("R3 la copy", v, 16'h0845);
    rd(0, v); chk("R4 la step", v, 16'h0846);
    wr(1, 16'hF040);
    rd(1, v); chk("R3 13 bits", v, 16'h1040);
    rd(3, v); chk("R3 ned", v, 16'h8880);
    rd(0, v); chk("R4 la bad", v, 16'h8847);
    wr(1, 16'h0000);
    rd(3, v); chk("R3 ned clr", v, 16'h0080);
    wr(1, 16'h083F);
    rd(0, v); chk("R4 la", v, 16'h083F);
    rd(0, v); chk("R4 wrap", v, 16'h0800);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    wr(4, 16'h1234); wr(4, 16'h00AB, 1, 1);
    rd(4, v); chk("R2 odd", v, 16'hAB34);
    wr(4, 16'h00CD, 1, 0);
    rd(4, v); chk("R2 even", v, 16'hABCD);
    wr(5, 16'h1235); rd(5, v); chk("R9 ca bit0", v, 16'h1234);
    wr(5, 16'h0057, 1, 0); rd(5, v); chk("R2 ca byte", v, 16'h1256);
    wr(6, 16'hFFFF); rd(6, v); chk("R9 mn mask", v, 16'hFFC0);
  endtask

  task automatic t_ctl();
    logic [15:0] v;
    wr(3, 16'hFEFE);
    rd(3, v); chk("R9 writable", v, 16'h02FE);
    chk("R8 ie after done", {15'b0, irq}, 16'h1);
    chk("R5 mem addr", seq_mem_addr[15:0], 16'h1256);
    chk("R5 mex", {14'b0, seq_mem_addr[17:16]}, 16'h3);
    wr(3, 16'h0000);
    chk("R8 ie clr", {15'b0, irq}, 16'h0);
    rd(3, v); chk("R5 cs", v, 16'h0080);
  endtask

  task automatic t_go();
    logic [15:0] v;
    wr(1, 16'h0010);
    @(negedge clk); seq_er_set = 16'h0020; seq_err_set = 5'b00001;
    @(negedge clk); seq_er_set = '0; seq_err_set = '0;
    rd(3, v); chk("R5 summary", v, 16'h8480);
    rd(2, v); chk("R11 er", v, 16'h0020);
    wr(3, 16'h0045);
    chk("R6 start", {15'b0, seq_start}, 16'h1);
    chk("R6 func", {14'b0, seq_func}, 16'h2);
    rd(3, v); chk("R6 cleared", v, 16'h0044);
    rd(2, v); chk("R6 er clr", v, 16'h0);
    wr(3, 16'h0047);
    chk("R6 busy no start", {15'b0, seq_start}, 16'h0);
    chk("R6 func kept", {14'b0, seq_func}, 16'h2);
    @(negedge clk); seq_done = 1; seq_er_set = 16'h0020;
    @(negedge clk); seq_done = 0; seq_er_set = '0; #1;
    chk("R8 irq rise", {15'b0, irq}, 16'h1);
    rd(3, v); chk("R11 done", v, 16'h80C6);
    rd(0, v); chk("R4 ovfl bad", v, 16'h8010);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    wr(3, 16'h0001);
    chk("R6 start2", {15'b0, seq_start}, 16'h1);
    rd(3, v); chk("R6 busy", v, 16'h0000);
    wr(3, 16'h0100);
    chk("R7 abort", {15'b0, seq_abort}, 16'h1);
    rd(3, v); chk("R7 done", v, 16'h0080);
    chk("R8 no ie", {15'b0, irq}, 16'h0);
    wr(3, 16'h0041);
    wr(3, 16'h0140);
    chk("R8 abort irq", {15'b0, irq}, 16'h1);
    @(negedge clk); seq_db_load = 1; seq_db_val = 16'h5A5A;
    @(negedge clk); seq_db_load = 0;
    rd(7, v); chk("R11 db", v, 16'h5A5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readonly();
    t_daddr();
    t_bytes();
    t_ctl();
    t_go();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule